// File: doc/BRIEF.md
# Converter Serial Register Port

This block is the slave side of the serial port of a 12-bit converter together with the register file behind it. A host frames each transfer by pulling an active-low sync line low and then supplies a serial clock; every complete frame carries 16 bits in each direction at the same time. The incoming word is decoded by its two top bits. These bits select the test register, one of four calibration coefficient registers, or the control register, or they select nothing. The outgoing word comes from whichever register the read-select field of the control register names. That field is held until software writes it again.

The serial clock, sync and data pins are synchronised into the system clock domain, and all decisions are taken on detected edges. The conversion sequencer sees the control register as plain outputs: channel, power, calibration and start bits. It answers with one-cycle done pulses. A conversion-done pulse also captures the new result. The software start bits clear themselves when the matching done pulse arrives. The interface-mode bit clears after every complete frame that does not rewrite the control register.

Top module: `adc_serial_regif`

## Requirements
- R1: A frame is the bits sampled on the first 16 detected rising edges of the serial clock while sync is low, taken most significant bit first. The addressed register is written only after the 16th bit has been taken. Rising edges beyond the 16th in the same frame are ignored.
- R2: The frame's bits 15:14 are the address and bits 13:0 the payload. Address 2'b01 writes the test register and 2'b11 the control register. Address 2'b10 writes a calibration register. Address 2'b00 changes no register.
- R3: A frame in which sync returns high before the 16th rising edge leaves every register unchanged.
- R4: The control register resets to zero. Its fields, from bit 13 down, are: input-mode 13, channel 12:10, power 9:8, read-select 7:6, interface-mode 5, convert-start 4, calibration-mode 3, calibration-select 2:1, start-calibration 0.
- R5: Read-select picks the word shifted out in every later frame until the control register is written again. The codes are 00 result, 01 test, 10 calibration, 11 status.
- R6: A conversion-done pulse captures the 12-bit result. A result read returns four zero bits above that result.
- R7: A test read returns {2'b00, test}. A status read returns {2'b01, control}.
- R8: Every complete frame that does not address the control register clears the interface-mode bit.
- R9: A conversion-done pulse clears convert-start. A control write in the same cycle takes precedence.
- R10: A calibration-done pulse clears start-calibration. A control write in the same cycle takes precedence.
- R11: With start-calibration at 0, calibration-select chooses which of the four coefficient registers is written and read. With start-calibration at 1, calibration writes are discarded and calibration reads return zero.
- R12: The data-out enable is low while sync is high. The read word's MSB is presented when the frame opens. Each later bit appears after a serial-clock falling edge that follows a sampled rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| sync_n | input | 1 | Active-low frame sync |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Drive enable for dout |
| adc_result | input | 12 | Conversion result from the core |
| conv_done | input | 1 | One-cycle pulse at conversion end |
| cal_done | input | 1 | One-cycle pulse at calibration end |
| ctrl_word | output | 14 | Control register contents |
| test_word | output | 14 | Test register contents |
| cal_coefs | output | 56 | Four calibration coefficients, entry n at bits 14n+13:14n |

## Verification
The assertions assume that sync_n and the done pulses are plain synchronous-level inputs that are low or high for whole clock cycles. They also assume that done pulses are single-cycle and are not raised during reset. The stimulus holds every serial-clock phase for several system clocks, so each edge survives the synchroniser. It changes din only while the serial clock is low. It issues done pulses only between frames, which keeps the frame-completion strobe and the auto-clear paths apart except where an assertion covers their overlap.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;
  localparam int FRAME_W   = 16;
  localparam int ADDR_W    = 2;
  localparam int PAY_W     = FRAME_W - ADDR_W;
  localparam int CSEL_W    = 2;
  localparam int CAL_N     = 1 << CSEL_W;
  localparam int CNT_W     = $clog2(FRAME_W + 1);

  typedef enum logic [ADDR_W-1:0] {
    DST_NONE = 2'b00,
    DST_TEST = 2'b01,
    DST_CAL  = 2'b10,
    DST_CTRL = 2'b11
  } dst_e;

  typedef enum logic [1:0] {
    RD_RESULT = 2'b00,
    RD_TEST   = 2'b01,
    RD_CAL    = 2'b10,
    RD_STATUS = 2'b11
  } rsel_e;

  typedef struct packed {
    logic              in_mode;
    logic [2:0]        chan;
    logic [1:0]        pwr;
    rsel_e             rsel;
    logic              if_mode;
    logic              conv_go;
    logic              cal_mode;
    logic [CSEL_W-1:0] cal_sel;
    logic              cal_go;
  } ctrl_t;

  localparam logic [1:0] STATUS_TAG = 2'b01;
endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sync_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic frame_start,
  output logic frame_active,
  output logic din_s
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sclk_p, sync_p, din_p;
  logic              sclk_l, sync_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '1;
      sync_p <= '1;
      din_p  <= '0;
      sclk_l <= 1'b1;
      sync_l <= 1'b1;
    end else begin
      sclk_p[0] <= sclk;
      sync_p[0] <= sync_n;
      din_p[0]  <= din;
      for (int i = 1; i < STAGES; i++) begin
        sclk_p[i] <= sclk_p[i-1];
        sync_p[i] <= sync_p[i-1];
        din_p[i]  <= din_p[i-1];
      end
      sclk_l <= sclk_p[LAST];
      sync_l <= sync_p[LAST];
    end
  end

  assign sclk_rise    = sclk_p[LAST] & ~sclk_l;
  assign sclk_fall    = ~sclk_p[LAST] & sclk_l;
  assign frame_active = ~sync_p[LAST];
  assign frame_start  = sync_l & ~sync_p[LAST];
  assign din_s        = din_p[LAST];
endmodule

// File: rtl/adc_sif_shift.sv
module adc_sif_shift
  import adc_sif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               frame_start,
  input  logic               frame_active,
  input  logic               din_s,
  input  logic [FRAME_W-1:0] load_word,
  output logic               dout,
  output logic [FRAME_W-1:0] rx_word,
  output logic               frame_done
);
  logic [FRAME_W-1:0] tx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               room;

  assign room = (cnt_q < CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q       <= '0;
      rx_word    <= '0;
      cnt_q      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (frame_start) begin
        tx_q  <= load_word;
        cnt_q <= '0;
      end else if (frame_active) begin
        if (sclk_rise && room) begin
          rx_word    <= {rx_word[FRAME_W-2:0], din_s};
          cnt_q      <= cnt_q + 1'b1;
          frame_done <= (cnt_q == CNT_W'(FRAME_W - 1));
        end
        if (sclk_fall && room && (cnt_q != '0)) begin
          tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign dout = tx_q[FRAME_W-1];
endmodule

// File: rtl/adc_sif_regs.sv
module adc_sif_regs
  import adc_sif_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [FRAME_W-1:0]     rx_word,
  input  logic                   conv_done,
  input  logic                   cal_done,
  input  logic [RES_W-1:0]       adc_result,
  output ctrl_t                  ctrl_q,
  output logic [PAY_W-1:0]       test_q,
  output logic [CAL_N*PAY_W-1:0] cal_flat,
  output logic [FRAME_W-1:0]     rd_word,
  output logic                   ctrl_wr
);
  localparam int PAD_W = FRAME_W - RES_W;

  dst_e             dst;
  logic [PAY_W-1:0] payload;
  logic             test_wr, cal_wr;
  logic [RES_W-1:0] result_q;
  logic [PAY_W-1:0] cal_r [CAL_N];

  assign dst     = dst_e'(rx_word[FRAME_W-1 -: ADDR_W]);
  assign payload = rx_word[PAY_W-1:0];
  assign ctrl_wr = commit && (dst == DST_CTRL);
  assign test_wr = commit && (dst == DST_TEST);
  assign cal_wr  = commit && (dst == DST_CAL) && !ctrl_q.cal_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_t'(payload);
    end else begin
      if (commit)    ctrl_q.if_mode <= 1'b0;
      if (conv_done) ctrl_q.conv_go <= 1'b0;
      if (cal_done)  ctrl_q.cal_go  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       test_q <= '0;
    else if (test_wr) test_q <= payload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (conv_done) result_q <= adc_result;
  end

  for (genvar g = 0; g < CAL_N; g++) begin : g_cal
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cal_r[g] <= '0;
      else if (cal_wr && (ctrl_q.cal_sel == CSEL_W'(g)))
        cal_r[g] <= payload;
    end
    assign cal_flat[g*PAY_W +: PAY_W] = cal_r[g];
  end

  always_comb begin
    unique case (ctrl_q.rsel)
      RD_RESULT: rd_word = {{PAD_W{1'b0}}, result_q};
      RD_TEST:   rd_word = {{ADDR_W{1'b0}}, test_q};
      RD_CAL:    rd_word = ctrl_q.cal_go ? '0
                                         : {{ADDR_W{1'b0}}, cal_r[ctrl_q.cal_sel]};
      default:   rd_word = {STATUS_TAG, PAY_W'(ctrl_q)};
    endcase
  end
endmodule

// File: rtl/adc_serial_regif.sv
module adc_serial_regif
  import adc_sif_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   sync_n,
  input  logic                   din,
  output logic                   dout,
  output logic                   dout_oe,
  input  logic [RES_W-1:0]       adc_result,
  input  logic                   conv_done,
  input  logic                   cal_done,
  output logic [PAY_W-1:0]       ctrl_word,
  output logic [PAY_W-1:0]       test_word,
  output logic [CAL_N*PAY_W-1:0] cal_coefs
);
  logic               sclk_rise, sclk_fall, frame_start, frame_active, din_s;
  logic [FRAME_W-1:0] rx_word, rd_word;
  logic               frame_done, ctrl_wr;
  ctrl_t              ctrl_q;

  adc_sif_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .sync_n       (sync_n),
    .din          (din),
    .sclk_rise    (sclk_rise),
    .sclk_fall    (sclk_fall),
    .frame_start  (frame_start),
    .frame_active (frame_active),
    .din_s        (din_s)
  );

  adc_sif_shift i_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_rise    (sclk_rise),
    .sclk_fall    (sclk_fall),
    .frame_start  (frame_start),
    .frame_active (frame_active),
    .din_s        (din_s),
    .load_word    (rd_word),
    .dout         (dout),
    .rx_word      (rx_word),
    .frame_done   (frame_done)
  );

  adc_sif_regs #(.RES_W(RES_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (frame_done),
    .rx_word    (rx_word),
    .conv_done  (conv_done),
    .cal_done   (cal_done),
    .adc_result (adc_result),
    .ctrl_q     (ctrl_q),
    .test_q     (test_word),
    .cal_flat   (cal_coefs),
    .rd_word    (rd_word),
    .ctrl_wr    (ctrl_wr)
  );

  assign dout_oe   = frame_active;
  assign ctrl_word = PAY_W'(ctrl_q);
endmodule

// File: rtl/adc_sif_checker.sv
module adc_sif_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sync_n,
  input logic        dout_oe,
  input logic        commit,
  input logic        ctrl_wr,
  input logic        conv_done,
  input logic        cal_done,
  input logic [13:0] ctrl_word,
  input logic [13:0] test_word
);
  // R3: without a completed frame or a done pulse the control register holds
  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !conv_done && !cal_done) |=> $stable(ctrl_word));

  // R3: the test register changes only at frame completion
  a_r3_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(test_word));

  // R8: a completed frame that does not address control clears interface-mode
  a_r8_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !ctrl_wr) |=> !ctrl_word[5]);

  // R9: conversion end clears convert-start unless control is written
  a_r9_conv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !ctrl_wr) |=> !ctrl_word[4]);

  // R10: calibration end clears start-calibration unless control is written
  a_r10_cal_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !ctrl_wr) |=> !ctrl_word[0]);

  // R12: sync held high long enough to pass the synchroniser disables dout
  a_r12_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && $past(sync_n) && $past(sync_n, 2)) |-> !dout_oe);
endmodule

bind adc_serial_regif adc_sif_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_n    (sync_n),
  .dout_oe   (dout_oe),
  .commit    (frame_done),
  .ctrl_wr   (ctrl_wr),
  .conv_done (conv_done),
  .cal_done  (cal_done),
  .ctrl_word (ctrl_word),
  .test_word (test_word)
);

// File: tb/test_adc_serial_regif.sv
module test_adc_serial_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        sync_n = 1'b1;
  logic        din = 1'b0;
  logic        dout, dout_oe;
  logic [11:0] adc_result = '0;
  logic        conv_done = 1'b0;
  logic        cal_done = 1'b0;
  logic [13:0] ctrl_word, test_word;
  logic [55:0] cal_coefs;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [13:0] ctrl_m, test_m;
  logic [13:0] cal_m [4];
  logic [11:0] data_m;

  always #5 clk = ~clk;

  adc_serial_regif i_adc_serial_regif (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .adc_result(adc_result),
    .conv_done(conv_done), .cal_done(cal_done), .ctrl_word(ctrl_word),
    .test_word(test_word), .cal_coefs(cal_coefs)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read();
    case (ctrl_m[7:6])
      2'b00:   return {4'b0000, data_m};
      2'b01:   return {2'b00, test_m};
      2'b10:   return ctrl_m[0] ? 16'h0000 : {2'b00, cal_m[ctrl_m[2:1]]};
      default: return {2'b01, ctrl_m};
    endcase
  endfunction

  function automatic void model_commit(input logic [15:0] w);
    case (w[15:14])
      2'b01: test_m = w[13:0];
      2'b10: if (!ctrl_m[0]) cal_m[ctrl_m[2:1]] = w[13:0];
      2'b11: ctrl_m = w[13:0];
      default: ;
    endcase
    if (w[15:14] != 2'b11) ctrl_m[5] = 1'b0;
  endfunction

  // Runs nbits serial-clock cycles; bits past 16 are driven as ones.
  task automatic frame(input logic [15:0] w, input int nbits, output logic [15:0] rd);
    rd = '0;
    @(negedge clk); sync_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(dout_oe == 1'b1, "R12 oe in frame", 64'(dout_oe), 64'd1);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      din  = (i < 16) ? w[15-i] : 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      if (i < 16) rd[15-i] = dout;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] w, input string req);
    logic [15:0] rd, e;
    e = exp_read();
    frame(w, 16, rd);
    chk(rd == e, req, 64'(rd), 64'(e));
    model_commit(w);
    chk(ctrl_word == ctrl_m, "R2 ctrl", 64'(ctrl_word), 64'(ctrl_m));
    chk(test_word == test_m, "R2 test", 64'(test_word), 64'(test_m));
    for (int k = 0; k < 4; k++)
      chk(cal_coefs[k*14 +: 14] == cal_m[k], "R11 coef", 64'(cal_coefs[k*14 +: 14]),
          64'(cal_m[k]));
  endtask

  task automatic pulse_conv(input logic [11:0] r);
    @(negedge clk); adc_result = r; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    data_m = r; ctrl_m[4] = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_cal();
    @(negedge clk); cal_done = 1'b1;
    @(negedge clk); cal_done = 1'b0;
    ctrl_m[0] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, e;
    void'($urandom(32'h1c0ffee5));
    ctrl_m = '0; test_m = '0; data_m = '0;
    for (int k = 0; k < 4; k++) cal_m[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 reset state, R12 idle enable
    chk(ctrl_word == 14'h0, "R4 reset ctrl", 64'(ctrl_word), 64'd0);
    chk(test_word == 14'h0, "R4 reset test", 64'(test_word), 64'd0);
    chk(dout_oe == 1'b0, "R12 idle oe", 64'(dout_oe), 64'd0);

    // R6 result capture and format; R2 address 00 discarded
    pulse_conv(12'hABC);
    xfer(16'h3FFF, "R6 result read");
    chk(ctrl_word == 14'h0, "R2 addr00 ignored", 64'(ctrl_word), 64'd0);

    // R2 test write, R7 test read through R5 select 01
    xfer(16'h4000 | 16'h1234, "R2 test write");
    xfer(16'hC000 | 16'h0040, "R5 select test");
    xfer(16'h0000, "R7 test read");

    // R3 short frame leaves registers alone
    frame(16'hFFFF, 10, rd);
    chk(ctrl_word == ctrl_m, "R3 short ctrl", 64'(ctrl_word), 64'(ctrl_m));
    chk(test_word == test_m, "R3 short test", 64'(test_word), 64'(test_m));

    // R5 status select persists; R7 status format; R8 mode clear
    xfer(16'hC000 | 16'h00E0, "R5 to status");
    chk(ctrl_word[5] == 1'b1, "R8 mode set", 64'(ctrl_word[5]), 64'd1);
    xfer(16'h0000, "R7 status read");
    chk(ctrl_word[5] == 1'b0, "R8 mode cleared", 64'(ctrl_word[5]), 64'd0);
    xfer(16'h4000 | 16'h0005, "R5 status persists");

    // R1 extra rising edges ignored
    e = exp_read();
    frame(16'h4321, 20, rd);
    model_commit(16'h4321);
    chk(rd == e, "R1 long frame read", 64'(rd), 64'(e));
    chk(test_word == 14'h0321, "R1 long frame commit", 64'(test_word), 64'h0321);

    // R9 convert-start clears on conversion end
    xfer(16'hC000 | 16'h0010, "R9 set conv");
    chk(ctrl_word[4] == 1'b1, "R9 conv set", 64'(ctrl_word[4]), 64'd1);
    pulse_conv(12'h5A5);
    chk(ctrl_word[4] == 1'b0, "R9 conv cleared", 64'(ctrl_word[4]), 64'd0);
    xfer(16'h0000, "R6 second result");

    // R11 coefficient select, R10 start-calibration lock and clear
    xfer(16'hC000 | 16'h0084, "R11 select cal2");
    xfer(16'h8000 | 16'h2BCD, "R11 write cal2");
    xfer(16'h0000, "R11 read cal2");
    xfer(16'hC000 | 16'h0083, "R10 start cal");
    xfer(16'h8000 | 16'h1111, "R11 locked read zero");
    chk(cal_coefs[14 +: 14] == 14'h0, "R11 locked write", 64'(cal_coefs[14 +: 14]), 64'd0);
    pulse_cal();
    chk(ctrl_word[0] == 1'b0, "R10 cal cleared", 64'(ctrl_word[0]), 64'd0);
    xfer(16'h8000 | 16'h0777, "R11 unlocked write");

    // Random mix of frames and done pulses
    for (int it = 0; it < 60; it++) begin
      int c = $urandom_range(0, 3);
      if (c == 0) pulse_conv(12'($urandom));
      else if (c == 1) pulse_cal();
      xfer(16'($urandom), "R5 random read");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule